// File: doc/BRIEF.md
# Multiband Hysteresis Level Selector

This block is the current-error controller for one phase of a five-level inverter leg. On each sample enable it takes the signed current error (reference minus measured) and sorts its magnitude against three programmable thresholds. Each side of zero has two tracking bands and one outer band. From these crossings it picks one of five output levels. The levels are coded as a signed index from -2 to +2 and stand for -Vdc/2, -Vdc/4, 0, +Vdc/4 and +Vdc/2. A separate stage turns the index into a switch pattern.

During normal tracking, each new band crossing moves the index by exactly one step. This keeps the output waveform free of two-level jumps. The optional outer band handles fast transients: when it is enabled, an error that reaches it forces the extreme level that opposes the error. A crossing history gives the thresholds hysteresis, so an error that dithers on a boundary does not make the output chatter. A one-cycle strobe marks every change of the index.

Top module: `hyst_level_sel`

## Requirements
- R1: The level index `levelIdx` is 3-bit two's complement and is always in -2..+2. A synchronous reset sets it to 0 and clears `levelStep` and the crossing history.
- R2: The error magnitude is graded into zones: 1 when |err| >= `thrInner`, 2 when >= `thrMid`, 3 when >= `thrOuter`, otherwise 0. All thresholds are inclusive. A positive error that enters a zone higher than the highest one reached on the positive side since the history was last cleared raises the index by one, saturating at +2.
- R3: A negative error that does the same on the negative side lowers the index by one, saturating at -2.
- R4: A sample with |err| < `thrInner` leaves the index unchanged and clears the crossing history.
- R5: Re-entering a zone that has already been reached on the same side, without first passing inside the inner band, leaves the index unchanged.
- R6: An error that jumps over several tracking zones in one sample still moves the index by only one step.
- R7: With `outerEn` high, a sample in zone 3 forces the index to +2 for a positive error or -2 for a negative error in that one sample. With `outerEn` low, zone 3 acts as an ordinary one-step crossing.
- R8: `levelStep` is high for exactly the one cycle in which a new index value first appears. It stays low when a requested step is absorbed by saturation.
- R9: While `sampleEn` is low, the index does not change and `levelStep` stays low, whatever the error.
- R10: A sample in a positive zone taken directly after one in a negative zone counts as a fresh positive crossing, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | Sample enable; the error is evaluated on cycles where it is high |
| errIn | input | ErrW | Signed current error, reference minus measured |
| thrInner | input | ErrW | Inner tracking threshold magnitude (unsigned) |
| thrMid | input | ErrW | Second tracking threshold magnitude (unsigned) |
| thrOuter | input | ErrW | Outer transient threshold magnitude (unsigned) |
| outerEn | input | 1 | Enables forcing the extreme level in zone 3 |
| levelIdx | output | 3 | Selected level, signed -2..+2 |
| levelStep | output | 1 | One-cycle strobe on every index change |

## Verification
The bench drives errors that sit exactly on a threshold, to catch a comparison that should be inclusive but is strict. It makes an error skip from inside the inner band straight into the second band; a design that counted every skipped zone would jump two levels. It makes the error dither across a boundary without returning to the centre, to expose missing hysteresis, which shows up as a climbing index. It also drives saturation and sign reversals: a strobe raised with no change, or an opposite-side crossing lost because of stale history, both show up at the ports.

// File: rtl/hyst_lvl_pkg.sv
package hyst_lvl_pkg;
  typedef logic signed [2:0] zone_t;
  typedef logic signed [2:0] level_t;

  localparam level_t LevelMax = 3'sd2;
  localparam level_t LevelMin = -3'sd2;
  localparam zone_t  ZoneOuter = 3'sd3;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic forceHi;
    logic forceLo;
  } lvlCmd_t;
endpackage

// File: rtl/hyst_lvl_datapath.sv
module hyst_lvl_datapath
  import hyst_lvl_pkg::*;
#(
  parameter int ErrW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sampleEn,
  input  logic signed [ErrW-1:0] errIn,
  input  logic [ErrW-1:0]        thrInner,
  input  logic [ErrW-1:0]        thrMid,
  input  logic [ErrW-1:0]        thrOuter,
  input  lvlCmd_t                cmd,
  output zone_t                  zone,
  output level_t                 levelIdx,
  output logic                   levelStep
);
  localparam int MagW = ErrW + 1;
  localparam int NumBands = 3;

  logic signed [MagW-1:0] errExt;
  logic [MagW-1:0] errMag;
  logic [MagW-1:0] thrArr [NumBands];
  logic [NumBands-1:0] aboveBand;
  logic [1:0] zoneMag;
  level_t levelNext;

  assign errExt = {errIn[ErrW-1], errIn};
  assign errMag = errIn[ErrW-1] ? unsigned'(-errExt) : unsigned'(errExt);
  assign thrArr[0] = {1'b0, thrInner};
  assign thrArr[1] = {1'b0, thrMid};
  assign thrArr[2] = {1'b0, thrOuter};

  for (genvar b = 0; b < NumBands; b++) begin : g_band
    assign aboveBand[b] = (errMag >= thrArr[b]);
  end

  always_comb begin
    zoneMag = 2'd0;
    for (int b = 0; b < NumBands; b++) begin
      if (aboveBand[b]) zoneMag = 2'(b + 1);
    end
  end

  assign zone = errIn[ErrW-1] ? -zone_t'({1'b0, zoneMag}) : zone_t'({1'b0, zoneMag});

  always_comb begin
    levelNext = levelIdx;
    if (cmd.forceHi) levelNext = LevelMax;
    else if (cmd.forceLo) levelNext = LevelMin;
    else if (cmd.stepUp && levelIdx < LevelMax) levelNext = levelIdx + 3'sd1;
    else if (cmd.stepDown && levelIdx > LevelMin) levelNext = levelIdx - 3'sd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      levelIdx  <= '0;
      levelStep <= 1'b0;
    end else if (sampleEn) begin
      levelIdx  <= levelNext;
      levelStep <= (levelNext != levelIdx);
    end else begin
      levelStep <= 1'b0;
    end
  end

  logic signed [3:0] levelExt;
  assign levelExt = {levelIdx[2], levelIdx};

  assert_level_range_R1: assert property (@(posedge clk) disable iff (rst)
    (levelIdx >= LevelMin) && (levelIdx <= LevelMax));

  assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd.forceHi || cmd.forceLo) |->
      ((levelExt - $past(levelExt)) <= 4'sd1) && ((levelExt - $past(levelExt)) >= -4'sd1));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(sampleEn) |-> $stable(levelIdx) && !levelStep);

  assert_inner_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $past(sampleEn && zone == 3'sd0) |-> $stable(levelIdx));

  assert_strobe_on_change_R8: assert property (@(posedge clk) disable iff (rst)
    (levelIdx != $past(levelIdx)) |-> levelStep);
endmodule

// File: rtl/hyst_lvl_control.sv
module hyst_lvl_control
  import hyst_lvl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sampleEn,
  input  logic    outerEn,
  input  zone_t   zone,
  output lvlCmd_t cmd
);
  zone_t peakZone;
  zone_t posPeak;
  zone_t negPeak;
  logic  newPos;
  logic  newNeg;

  assign posPeak = (peakZone > 3'sd0) ? peakZone : 3'sd0;
  assign negPeak = (peakZone < 3'sd0) ? peakZone : 3'sd0;
  assign newPos  = (zone > 3'sd0) && (zone > posPeak);
  assign newNeg  = (zone < 3'sd0) && (zone < negPeak);

  always_comb begin
    cmd = '0;
    if (sampleEn) begin
      cmd.stepUp   = newPos;
      cmd.stepDown = newNeg;
      cmd.forceHi  = outerEn && (zone == ZoneOuter);
      cmd.forceLo  = outerEn && (zone == -ZoneOuter);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      peakZone <= '0;
    end else if (sampleEn) begin
      if (zone == 3'sd0) peakZone <= '0;
      else if (newPos || newNeg) peakZone <= zone;
    end
  end

  assert_dir_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.stepUp | cmd.forceHi, cmd.stepDown | cmd.forceLo}));

  assert_no_repeat_R5: assert property (@(posedge clk) disable iff (rst)
    $past(sampleEn && zone > 3'sd0) && sampleEn && $stable(zone) |-> !cmd.stepUp);
endmodule

// File: rtl/hyst_level_sel.sv
module hyst_level_sel
  import hyst_lvl_pkg::*;
#(
  parameter int ErrW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sampleEn,
  input  logic signed [ErrW-1:0] errIn,
  input  logic [ErrW-1:0]        thrInner,
  input  logic [ErrW-1:0]        thrMid,
  input  logic [ErrW-1:0]        thrOuter,
  input  logic                   outerEn,
  output logic signed [2:0]      levelIdx,
  output logic                   levelStep
);
  lvlCmd_t cmd;
  zone_t   zone;

  hyst_lvl_control u_control (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .outerEn(outerEn),
    .zone(zone), .cmd(cmd)
  );

  hyst_lvl_datapath #(.ErrW(ErrW)) u_datapath (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .errIn(errIn),
    .thrInner(thrInner), .thrMid(thrMid), .thrOuter(thrOuter),
    .cmd(cmd), .zone(zone), .levelIdx(levelIdx), .levelStep(levelStep)
  );
endmodule

// File: tb/hyst_level_sel_bench.sv
module hyst_level_sel_bench;
  localparam int ClkPeriod = 10;
  localparam int ErrW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleEn = 1'b0;
  logic signed [ErrW-1:0] errIn = '0;
  logic [ErrW-1:0] thrInner = 16'd100;
  logic [ErrW-1:0] thrMid = 16'd200;
  logic [ErrW-1:0] thrOuter = 16'd300;
  logic outerEn = 1'b0;
  logic signed [2:0] levelIdx;
  logic levelStep;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #(ClkPeriod/2) clk = ~clk;

  hyst_level_sel #(.ErrW(ErrW)) u_hyst_level_sel (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .errIn(errIn),
    .thrInner(thrInner), .thrMid(thrMid), .thrOuter(thrOuter),
    .outerEn(outerEn), .levelIdx(levelIdx), .levelStep(levelStep)
  );

  task automatic check(string req, int expLvl, bit expStep);
    testsRun++;
    if (int'(levelIdx) != expLvl || levelStep !== expStep) begin
      testsFailed++;
      $display("FAIL %s: level=%0d step=%0b expected level=%0d step=%0b",
               req, levelIdx, levelStep, expLvl, expStep);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; sampleEn = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic sample(int e);
    @(negedge clk); errIn = 16'(e); sampleEn = 1'b1;
    @(negedge clk); sampleEn = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    check("R1 reset", 0, 0);
  endtask

  task automatic t_up_saturate();
    doReset(); outerEn = 1'b0;
    sample(150); check("R2 first band up", 1, 1);
    sample(250); check("R2 second band up", 2, 1);
    sample(350); check("R7/R8 outer disabled saturates", 2, 0);
    sample(50);  check("R4 inside inner holds", 2, 0);
  endtask

  task automatic t_down();
    doReset(); outerEn = 1'b0;
    sample(-150); check("R3 first band down", -1, 1);
    sample(-250); check("R3 second band down", -2, 1);
    sample(-50);  check("R4 hold negative", -2, 0);
    sample(-100); check("R3 inclusive threshold", -2, 0);
  endtask

  task automatic t_hysteresis();
    doReset();
    sample(150); check("R5 setup", 1, 1);
    sample(120); check("R5 same zone", 1, 0);
    sample(210); check("R5 next zone", 2, 1);
    sample(150); check("R5 dropback", 2, 0);
    sample(230); check("R5 re-enter", 2, 0);
    sample(-150); check("R10 cross to negative", 1, 1);
    sample(150); check("R10 cross back positive", 2, 1);
  endtask

  task automatic t_skip();
    doReset();
    sample(250); check("R6 skip one step", 1, 1);
    sample(0);   check("R4 rearm hold", 1, 0);
    sample(100); check("R2 exact inner threshold", 2, 1);
  endtask

  task automatic t_outer();
    doReset(); outerEn = 1'b1;
    sample(299); check("R7 below outer", 1, 1);
    sample(300); check("R7 exact outer forces", 2, 1);
    sample(-50); check("R7 hold", 2, 0);
    sample(-320); check("R7 negative force", -2, 1);
    @(negedge clk); check("R8 strobe one cycle", -2, 0);
    outerEn = 1'b0;
  endtask

  task automatic t_idle();
    doReset();
    sample(150); check("R9 setup", 1, 1);
    @(negedge clk); errIn = 16'(250);
    @(negedge clk); @(negedge clk);
    check("R9 no sample", 1, 0);
    sample(250); check("R9 sample after idle", 2, 1);
  endtask

  initial begin
    t_reset();
    t_up_saturate();
    t_down();
    t_hysteresis();
    t_skip();
    t_outer();
    t_idle();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #(ClkPeriod * 100000);
    if (!finished) begin
      finished = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule